// File: doc/BRIEF.md
# Programmable Clock Divider with Duty-Cycle Mode

The block takes a base clock and produces two square-wave outputs from it. The first output is the base clock itself, passed through an enable gate. The second output is a divided version of the base clock. Its ratio comes from an 8-bit divide value N. A mode bit selects between two waveforms. Pulse mode divides by N+1 and shows one high phase of the base clock per period. Square mode divides by 2(N+1) and gives a 50% duty cycle.

Settings are loaded through a simple parallel write port. A divide write and a control write are told apart by a select line. A sequencer with three states generates the divided waveform:

- **PULSE**: pulse mode. The counter runs down from N, and the output is high only in the high phase of the cycle where the count reaches zero.
- **SQ_HIGH**: the first half of a square period. The output is high for N+1 whole base cycles.
- **SQ_LOW**: the second half of a square period. The output is low for N+1 whole base cycles.

The transitions are named as follows:

- **reload** (PULSE→PULSE or PULSE→SQ_HIGH, and SQ_LOW→SQ_HIGH or SQ_LOW→PULSE): taken at the end of a period. It adopts the pending divide value and mode.
- **half-turn** (SQ_HIGH→SQ_LOW): taken at the middle of a square period. It keeps the active divide value.

Both outputs are built from flops that change only while the base clock is in the opposite phase. A setting never cuts or stretches a phase, so no runt pulse appears.

Top module: `clock_divider`

## Requirements
- R1: While rst_n is low both outputs are low. After reset the divide value is 0, pulse mode is selected and both enables are on, so div_out follows the base clock.
- R2: In pulse mode (control bit 0 = 0) div_out repeats every N+1 base cycles. It is high only during the high phase of the last base cycle of each period, so N=0 reproduces the base clock.
- R3: In square mode (control bit 0 = 1) div_out repeats every 2(N+1) base cycles. It is high for the first N+1 whole base cycles of each period and low for the next N+1.
- R4: A write with wr_sel=0 loads N from wr_data[7:0]. A write with wr_sel=1 loads the control fields: bit 0 selects the mode, bit 2 enables base_out and bit 3 enables div_out. Control bit 1 (test, must stay 0) and bits 7:4 are ignored, and writing 1 to them changes neither output.
- R5: A divide value or mode written during a period takes effect only from the start of the next period. The current period, including the second half of a square period, completes with the old settings.
- R6: With the divided enable off, div_out stays low from the base cycle after the write. The divider keeps counting, so re-enabling resumes in the phase an uninterrupted run would have.
- R7: With the base enable on, base_out is high in the high phase of every base cycle and low in the low phase. With it off, base_out stays low from the base cycle after the write.
- R8: The largest divide value N=255 gives a 256-cycle period in pulse mode and a 512-cycle period in square mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of clk |
| wr_sel | input | 1 | 0 = divide register, 1 = control register |
| wr_data | input | 8 | Write data |
| base_out | output | 1 | Gated base clock |
| div_out | output | 1 | Divided clock |

## Verification
The bench compares every high and low half-cycle of both outputs against a period-counting model. It goes after several corner cases:

- **N=0 in pulse mode.** A design that registers the pulse instead of gating the clock phase would hold the output high rather than toggling it.
- **Settings changed in mid-period, including during the high half of a square period.** A design that reloads at every count expiry would produce an uneven square period.
- **Enable off and on again.** A design that freezes its counter would come back out of phase.
- **Writes that set the test and unused control bits, and N=255 in both modes.** These catch field decoding and counter width errors.

// File: rtl/clock_divider_pkg.sv
package clock_divider_pkg;

    localparam int CTL_W = 8;

    localparam int CTL_MODE    = 0;
    localparam int CTL_TEST    = 1;
    localparam int CTL_BASE_EN = 2;
    localparam int CTL_DIV_EN  = 3;

    localparam logic SEL_DIVIDE  = 1'b0;
    localparam logic SEL_CONTROL = 1'b1;

    typedef enum logic [1:0] {
        ST_PULSE   = 2'd0,
        ST_SQ_HIGH = 2'd1,
        ST_SQ_LOW  = 2'd2
    } div_state_e;

endpackage

// File: rtl/clock_divider_cfg.sv
module clock_divider_cfg
    import clock_divider_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CTL_W-1:0] wr_data,
    output logic [DIV_W-1:0] pend_n,
    output logic             pend_mode,
    output logic             base_en,
    output logic             div_en
);

    // Test bit and upper nibble carry no function
    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{wr_data[CTL_W-1:4], wr_data[CTL_TEST]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_n    <= '0;
            pend_mode <= 1'b0;
            base_en   <= 1'b1;
            div_en    <= 1'b1;
        end else if (wr_en) begin
            if (wr_sel == SEL_DIVIDE) begin
                pend_n <= wr_data[DIV_W-1:0];
            end else begin
                pend_mode <= wr_data[CTL_MODE];
                base_en   <= wr_data[CTL_BASE_EN];
                div_en    <= wr_data[CTL_DIV_EN];
            end
        end
    end

endmodule

// File: rtl/clock_divider_seq.sv
module clock_divider_seq
    import clock_divider_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] pend_n,
    input  logic             pend_mode,
    output div_state_e       state,
    output logic [DIV_W-1:0] count,
    output logic [DIV_W-1:0] act_n,
    output logic             next_high,
    output logic             next_low
);

    div_state_e       state_d;
    logic [DIV_W-1:0] count_d;
    logic [DIV_W-1:0] act_n_d;
    logic             expiry;

    assign expiry = (count == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PULSE;
            count <= '0;
            act_n <= '0;
        end else begin
            state <= state_d;
            count <= count_d;
            act_n <= act_n_d;
        end
    end

    // Transitions: reload at period end, half-turn inside a square period
    always_comb begin
        state_d = state;
        count_d = count - 1'b1;
        act_n_d = act_n;
        if (expiry) begin
            unique case (state)
                ST_SQ_HIGH: begin
                    state_d = ST_SQ_LOW;
                    count_d = act_n;
                end
                ST_PULSE, ST_SQ_LOW: begin
                    act_n_d = pend_n;
                    count_d = pend_n;
                    state_d = pend_mode ? ST_SQ_HIGH : ST_PULSE;
                end
                default: begin
                    state_d = ST_PULSE;
                    count_d = '0;
                end
            endcase
        end
    end

    // Outputs: phase levels for the coming base cycle
    always_comb begin
        next_high = 1'b0;
        next_low  = 1'b0;
        unique case (state_d)
            ST_PULSE: begin
                next_high = (count_d == '0);
                next_low  = 1'b0;
            end
            ST_SQ_HIGH: begin
                next_high = 1'b1;
                next_low  = 1'b1;
            end
            ST_SQ_LOW: begin
                next_high = 1'b0;
                next_low  = 1'b0;
            end
            default: begin
                next_high = 1'b0;
                next_low  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clock_divider_gate.sv
module clock_divider_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic div_en,
    input  logic base_en,
    input  logic next_high,
    input  logic next_low,
    output logic div_out,
    output logic base_out
);

    logic hi_q;
    logic lo_q;
    logic base_q;

    // High-phase levels settle while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= 1'b0;
            base_q <= 1'b0;
        end else begin
            hi_q   <= div_en & next_high;
            base_q <= base_en;
        end
    end

    // Low-phase level settles while clk is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
        end else begin
            lo_q <= div_en & next_low;
        end
    end

    assign div_out  = clk ? hi_q : lo_q;
    assign base_out = clk & base_q;

endmodule

// File: rtl/clock_divider.sv
module clock_divider
    import clock_divider_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CTL_W-1:0] wr_data,
    output logic             base_out,
    output logic             div_out
);

    logic [DIV_W-1:0] pend_n;
    logic             pend_mode;
    logic             base_en;
    logic             div_en;
    div_state_e       seq_state;
    logic [DIV_W-1:0] seq_count;
    logic [DIV_W-1:0] seq_act_n;
    logic             next_high;
    logic             next_low;

    clock_divider_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pend_n    (pend_n),
        .pend_mode (pend_mode),
        .base_en   (base_en),
        .div_en    (div_en)
    );

    clock_divider_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_n    (pend_n),
        .pend_mode (pend_mode),
        .state     (seq_state),
        .count     (seq_count),
        .act_n     (seq_act_n),
        .next_high (next_high),
        .next_low  (next_low)
    );

    clock_divider_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_en    (div_en),
        .base_en   (base_en),
        .next_high (next_high),
        .next_low  (next_low),
        .div_out   (div_out),
        .base_out  (base_out)
    );

endmodule

// File: rtl/clock_divider_checker.sv
module clock_divider_checker
    import clock_divider_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_out,
    input logic             base_out,
    input logic             div_en,
    input logic             base_en,
    input div_state_e       state,
    input logic [DIV_W-1:0] count,
    input logic [DIV_W-1:0] act_n
);

    always @(negedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (div_out == 1'b0 && base_out == 1'b0);
        end
    end

    p_pulse_only_at_zero_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (state == ST_PULSE && count != '0) |-> !div_out);

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= act_n);

    p_high_half_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SQ_HIGH && count != '0) |=> state == ST_SQ_HIGH);

    p_ratio_held_mid_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |=> $stable(act_n));

    p_div_gated_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !$past(div_en) |-> !div_out);

    p_base_gated_r7: assert property (@(negedge clk) disable iff (!rst_n)
        !$past(base_en) |-> !base_out);

endmodule

bind clock_divider clock_divider_checker #(.DIV_W(DIV_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_out  (div_out),
    .base_out (base_out),
    .div_en   (div_en),
    .base_en  (base_en),
    .state    (seq_state),
    .count    (seq_count),
    .act_n    (seq_act_n)
);

// File: tb/clock_divider_test.sv
module clock_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       base_out;
    logic       div_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit run_model = 1'b0;
    string phase_tag = "R1";

    typedef struct {
        logic  dh;
        logic  dl;
        logic  bh;
        string tag;
    } exp_t;
    exp_t sb[$];

    // Reference: period position, adopting pending settings at period end
    int m_n = 0, m_mode = 0, m_len = 1, m_i = 0;
    int p_n = 0, p_mode = 0;
    int en_div = 1, en_base = 1;

    clock_divider uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .base_out (base_out),
        .div_out  (div_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (run_model) begin
            exp_t e;
            if (m_i == m_len - 1) begin
                m_n    = p_n;
                m_mode = p_mode;
                m_len  = m_mode ? 2 * (m_n + 1) : (m_n + 1);
                m_i    = 0;
            end else begin
                m_i = m_i + 1;
            end
            e.dh  = (en_div != 0) && (m_mode ? (m_i < m_n + 1) : (m_i == m_len - 1));
            e.dl  = (en_div != 0) && (m_mode != 0) && (m_i < m_n + 1);
            e.bh  = (en_base != 0);
            e.tag = phase_tag;
            sb.push_back(e);
            if (wr_en) begin
                if (wr_sel == 1'b0) begin
                    p_n = int'(wr_data);
                end else begin
                    p_mode  = int'(wr_data[0]);
                    en_base = int'(wr_data[2]);
                    en_div  = int'(wr_data[3]);
                end
            end
        end
    end

    // Monitor: compare both half-cycles of each base cycle
    initial begin
        logic h, l, bh, bl;
        forever begin
            @(posedge clk);
            #5;
            h  = div_out;
            bh = base_out;
            #10;
            l  = div_out;
            bl = base_out;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (h !== e.dh || l !== e.dl) begin
                    fails++;
                    $display("FAIL %s div_out: actual hi=%b lo=%b expected hi=%b lo=%b at %0t",
                             e.tag, h, l, e.dh, e.dl, $time);
                end
                checks++;
                if (bh !== e.bh || bl !== 1'b0) begin
                    fails++;
                    $display("FAIL R7 base_out: actual hi=%b lo=%b expected hi=%b lo=0 at %0t",
                             bh, bl, e.bh, $time);
                end
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #2 rst_n = 1'b0;
        // R1: quiet outputs during reset
        repeat (3) begin
            @(posedge clk);
            #5;
            checks++;
            if (div_out !== 1'b0 || base_out !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset high phase: actual div=%b base=%b expected 0 0", div_out, base_out);
            end
            #10;
            checks++;
            if (div_out !== 1'b0 || base_out !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset low phase: actual div=%b base=%b expected 0 0", div_out, base_out);
            end
        end
        @(posedge clk);
        #5 rst_n = 1'b1;
        run_model = 1'b1;
        phase_tag = "R1";
        run(6);

        phase_tag = "R2";
        wr(1'b0, 8'd3);
        run(16);
        wr(1'b0, 8'd1);
        run(8);
        wr(1'b0, 8'd0);
        run(6);

        phase_tag = "R4";
        wr(1'b1, 8'hFF);
        run(10);
        wr(1'b1, 8'hF2 | 8'h0C);
        run(10);

        phase_tag = "R3";
        wr(1'b1, 8'h0D);
        wr(1'b0, 8'd2);
        run(30);

        phase_tag = "R5";
        wr(1'b0, 8'd6);
        run(10);
        wr(1'b0, 8'd1);
        run(3);
        wr(1'b1, 8'h0C);
        run(30);
        wr(1'b1, 8'h0D);
        wr(1'b0, 8'd3);
        run(12);
        wr(1'b0, 8'd0);
        run(20);

        phase_tag = "R6";
        wr(1'b0, 8'd4);
        run(12);
        wr(1'b1, 8'h05);
        run(13);
        wr(1'b1, 8'h0D);
        run(25);
        wr(1'b1, 8'h0C);
        run(7);
        wr(1'b1, 8'h04);
        run(9);
        wr(1'b1, 8'h0C);
        run(15);

        phase_tag = "R7";
        wr(1'b1, 8'h08);
        run(8);
        wr(1'b1, 8'h0D);
        run(8);

        phase_tag = "R8";
        wr(1'b0, 8'd255);
        run(1100);
        wr(1'b1, 8'h0C);
        run(600);

        run(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual still running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule